// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block receives a one-bit serial stream, qualified by a serial clock, and shifts it into one of three configuration registers: a main register, an enhancement register and a nonvolatile-image register. The system clock samples the serial clock and the data. Every rising edge of the serial clock accepts one data bit.

Three plain select lines decide which register takes the bit. The code is written {frame_lock, alt_sel, nv_sel}. When nv_sel is high, it wins over frame_lock. The stream fills the chosen register least significant bit first. All three registers are visible in parallel at the outputs.

A one-cycle `written` pulse follows the end of each frame, so that downstream logic knows the new contents are complete. The serial input has no back-pressure. The sender paces bits with the serial clock, and the block takes every qualifying edge. A separate valid/ready handshake is therefore not present.

Top module: `serial_cfg_loader`

## Requirements
- R1: Exactly one bit is accepted for each low-to-high transition of `ser_clk`, as seen by `clk`. Holding `ser_clk` high, or taking it low, shifts nothing.
- R2: An accepted bit enters the MSB of the selected register, and the register shifts right. After W accepted bits, the first bit sits in bit 0 (LSB-first loading).
- R3: With code {frame_lock, alt_sel, nv_sel} = 3'b000, accepted bits go to `main_q`.
- R4: With code 3'b010, accepted bits go to `enh_q`.
- R5: With nv_sel=1 and alt_sel=0, accepted bits go to `nv_q` at either level of frame_lock (codes 3'b001 and 3'b101).
- R6: Codes 3'b011, 3'b100, 3'b110 and 3'b111 select nothing. Serial edges under these codes change no register.
- R7: A register that is not selected holds its contents through any number of accepted bits aimed at another destination.
- R8: `written` is high for exactly one `clk` cycle, in the cycle after the select code changes, if at least one bit was accepted under the previous code. A code change with no accepted bits gives no pulse.
- R9: An asynchronous active-low `rst_n` clears all three registers and `written` to zero, without waiting for a clock edge.
- R10: Register widths are parameters, defaulting to 20 (main), 8 (enhancement) and 20 (nonvolatile image).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock; its rising transition accepts one bit |
| ser_dat | input | 1 | Serial data bit |
| frame_lock | input | 1 | Select line, MSB of the code |
| alt_sel | input | 1 | Select line, middle bit of the code |
| nv_sel | input | 1 | Select line, LSB of the code; has priority over frame_lock |
| main_q | output | MAIN_W | Main register contents |
| enh_q | output | ENH_W | Enhancement register contents |
| nv_q | output | NV_W | Nonvolatile-image register contents |
| written | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong destination decode or a wrong shift direction shows up on the parallel outputs one system clock after the accepting edge, so every bit is observable almost at once. A lost or duplicated edge detection leaves the register off by one position. This stays visible until the next full frame overwrites it. Frame-tracking errors appear on `written` in the cycle right after a code change: a missing pulse, an extra pulse, or a pulse that is too long.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
  typedef enum logic [1:0] {DST_NONE, DST_MAIN, DST_ENH, DST_NV} dest_e;
  localparam int DEF_MAIN_W = 20;
  localparam int DEF_ENH_W  = 8;
  localparam int DEF_NV_W   = 20;
endpackage

// File: rtl/cfgload_decode.sv
module cfgload_decode
  import cfgload_pkg::*;
(
  input  logic  frame_lock,
  input  logic  alt_sel,
  input  logic  nv_sel,
  output dest_e dest
);
  always_comb begin
    unique case ({frame_lock, alt_sel, nv_sel})
      3'b000:         dest = DST_MAIN;
      3'b010:         dest = DST_ENH;
      3'b001, 3'b101: dest = DST_NV;   // nv_sel dominates frame_lock
      default:        dest = DST_NONE;
    endcase
  end
endmodule

// File: rtl/cfgload_edge.sv
module cfgload_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  output logic rise
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= ser_clk;
  end
  assign rise = ser_clk & ~prev;
endmodule

// File: rtl/cfgload_shift.sv
module cfgload_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/cfgload_frame.sv
module cfgload_frame #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              accept,
  output logic              written
);
  logic [CODE_W-1:0] code_q;
  logic              dirty;
  logic              changed;

  assign changed = (code != code_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      dirty   <= 1'b0;
      written <= 1'b0;
    end else begin
      code_q  <= code;
      written <= changed & dirty;
      if (accept)       dirty <= 1'b1;
      else if (changed) dirty <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgload_pkg::*;
#(
  parameter int MAIN_W = DEF_MAIN_W,
  parameter int ENH_W  = DEF_ENH_W,
  parameter int NV_W   = DEF_NV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              frame_lock,
  input  logic              alt_sel,
  input  logic              nv_sel,
  output logic [MAIN_W-1:0] main_q,
  output logic [ENH_W-1:0]  enh_q,
  output logic [NV_W-1:0]   nv_q,
  output logic              written
);
  localparam int CODE_W = 3;

  dest_e dest;
  logic  ser_rise;
  logic  accept;

  cfgload_decode u_dec (
    .frame_lock(frame_lock), .alt_sel(alt_sel), .nv_sel(nv_sel), .dest(dest)
  );

  cfgload_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .rise(ser_rise)
  );

  assign accept = ser_rise && (dest != DST_NONE);

  cfgload_shift #(.W(MAIN_W)) u_main (
    .clk(clk), .rst_n(rst_n), .en(ser_rise && dest == DST_MAIN),
    .din(ser_dat), .q(main_q)
  );
  cfgload_shift #(.W(ENH_W)) u_enh (
    .clk(clk), .rst_n(rst_n), .en(ser_rise && dest == DST_ENH),
    .din(ser_dat), .q(enh_q)
  );
  cfgload_shift #(.W(NV_W)) u_nv (
    .clk(clk), .rst_n(rst_n), .en(ser_rise && dest == DST_NV),
    .din(ser_dat), .q(nv_q)
  );

  cfgload_frame #(.CODE_W(CODE_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .code({frame_lock, alt_sel, nv_sel}),
    .accept(accept), .written(written)
  );
endmodule

// File: rtl/cfgload_checker.sv
module cfgload_checker #(
  parameter int MAIN_W = 20,
  parameter int ENH_W  = 8,
  parameter int NV_W   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_dat,
  input logic              frame_lock,
  input logic              alt_sel,
  input logic              nv_sel,
  input logic              ser_rise,
  input logic [MAIN_W-1:0] main_q,
  input logic [ENH_W-1:0]  enh_q,
  input logic [NV_W-1:0]   nv_q,
  input logic              written
);
  logic code_void;
  assign code_void = (alt_sel && nv_sel) || (frame_lock && !nv_sel);

  // R3 and R2: main register shifts right with the new bit at its MSB
  assert_main_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rise && !frame_lock && !alt_sel && !nv_sel) |=>
      main_q == {$past(ser_dat), $past(main_q[MAIN_W-1:1])});

  // R4: enhancement register loads under code 010
  assert_enh_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rise && !frame_lock && alt_sel && !nv_sel) |=>
      enh_q == {$past(ser_dat), $past(enh_q[ENH_W-1:1])});

  // R5: nonvolatile image loads whatever the level of frame_lock
  assert_nv_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rise && nv_sel && !alt_sel) |=>
      nv_q == {$past(ser_dat), $past(nv_q[NV_W-1:1])});

  // R6: codes that select nothing leave every register untouched
  assert_void_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rise && code_void) |=> ($stable(main_q) && $stable(enh_q) && $stable(nv_q)));

  // R7: a main-register frame leaves the other two untouched
  assert_others_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_lock && !alt_sel && !nv_sel) |=> ($stable(enh_q) && $stable(nv_q)));

  // R8: the end-of-frame pulse never lasts two cycles
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    written |=> !written);

  // R9: registers read zero while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R9: assert (main_q == '0 && enh_q == '0 && nv_q == '0 && !written);
    end
  end
endmodule

bind serial_cfg_loader cfgload_checker #(
  .MAIN_W(MAIN_W), .ENH_W(ENH_W), .NV_W(NV_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .frame_lock(frame_lock),
  .alt_sel(alt_sel), .nv_sel(nv_sel), .ser_rise(ser_rise),
  .main_q(main_q), .enh_q(enh_q), .nv_q(nv_q), .written(written)
);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;
  localparam int MW = 20, EW = 8, NW = 20;

  logic clk = 1'b0, rst_n = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic frame_lock = 1'b0, alt_sel = 1'b0, nv_sel = 1'b0;
  logic [MW-1:0] main_q;
  logic [EW-1:0] enh_q;
  logic [NW-1:0] nv_q;
  logic written;

  int tests = 0, fails = 0;
  logic [MW-1:0] m_main;
  logic [EW-1:0] m_enh;
  logic [NW-1:0] m_nv;
  bit m_dirty;

  always #4 clk = ~clk;

  serial_cfg_loader i_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .frame_lock(frame_lock), .alt_sel(alt_sel), .nv_sel(nv_sel),
    .main_q(main_q), .enh_q(enh_q), .nv_q(nv_q), .written(written)
  );

  // destination from code {frame_lock,alt_sel,nv_sel}: 0 none 1 main 2 enh 3 nv
  function automatic int dest_of(input logic [2:0] c);
    if (c == 3'b000) return 1;
    if (c == 3'b010) return 2;
    if (c == 3'b001 || c == 3'b101) return 3;
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(req, 32'(main_q), 32'(m_main));
    check(req, 32'(enh_q), 32'(m_enh));
    check(req, 32'(nv_q), 32'(m_nv));
  endtask

  task automatic model_bit(input logic b);
    case (dest_of({frame_lock, alt_sel, nv_sel}))
      1: begin m_main = {b, m_main[MW-1:1]}; m_dirty = 1; end
      2: begin m_enh  = {b, m_enh[EW-1:1]};  m_dirty = 1; end
      3: begin m_nv   = {b, m_nv[NW-1:1]};   m_dirty = 1; end
      default: ;
    endcase
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_dat = b; ser_clk = 1'b1;
    model_bit(b);
    @(negedge clk); ser_clk = 1'b0; ser_dat = ~b;
    @(negedge clk);
  endtask

  task automatic set_code(input logic [2:0] c);
    bit exp_pulse;
    @(negedge clk);
    exp_pulse = m_dirty && (c != {frame_lock, alt_sel, nv_sel});
    {frame_lock, alt_sel, nv_sel} = c;
    if (exp_pulse) m_dirty = 0;
    @(negedge clk);
    check("R8 pulse", 32'(written), 32'(exp_pulse));
    @(negedge clk);
    check("R8 width", 32'(written), 32'd0);
  endtask

  task automatic do_reset();
    #1 rst_n = 1'b0;
    #2;
    m_main = '0; m_enh = '0; m_nv = '0; m_dirty = 0;
    check_regs("R9 async clear");
    check("R9 written", 32'(written), 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] word;
    void'($urandom(32'h5A17));
    m_main = '0; m_enh = '0; m_nv = '0; m_dirty = 0;
    repeat (3) @(negedge clk);
    check_regs("R9 reset state");
    rst_n = 1'b1;

    // R2/R3: full main frame, LSB first
    set_code(3'b000);
    word = 32'h000A_5C3E;
    for (int i = 0; i < MW; i++) send_bit(word[i]);
    check("R2 main lsb first", 32'(main_q), 32'h000A_5C3E);
    check_regs("R3 main only");
    set_code(3'b010);

    // R4: enhancement frame
    word = 32'h0000_00B6;
    for (int i = 0; i < EW; i++) send_bit(word[i]);
    check("R4 enh", 32'(enh_q), 32'h0000_00B6);
    check_regs("R7 main kept");
    set_code(3'b101);

    // R5: nv frame with frame_lock high
    word = 32'h0009_1F42;
    for (int i = 0; i < NW; i++) send_bit(word[i]);
    check("R5 nv with lock high", 32'(nv_q), 32'h0009_1F42);
    set_code(3'b001);
    send_bit(1'b1);
    check_regs("R5 nv with lock low");

    // R1: holding ser_clk high accepts one bit only
    @(negedge clk); ser_dat = 1'b0; ser_clk = 1'b1; model_bit(1'b0);
    repeat (5) @(negedge clk);
    ser_dat = 1'b1;
    repeat (2) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    check_regs("R1 single bit per rise");

    // R6: void codes ignore edges
    set_code(3'b100); send_bit(1'b1); send_bit(1'b0);
    check_regs("R6 code 100");
    set_code(3'b011); send_bit(1'b1);
    check_regs("R6 code 011");
    set_code(3'b111); send_bit(1'b1);
    set_code(3'b110); send_bit(1'b0);
    check_regs("R6 codes 111/110");

    // R8: code change without any accepted bit gives no pulse
    set_code(3'b000);

    // random frames
    for (int k = 0; k < 60; k++) begin
      int n;
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      set_code(c);
      n = $urandom_range(1, 24);
      for (int i = 0; i < n; i++) send_bit(1'($urandom()));
      check_regs("R7 random frame");
      if (k == 30) begin
        do_reset();
        check_regs("R9 mid run");
      end
    end
    set_code(3'b110);
    check_regs("R10 widths final");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule